// File: doc/BRIEF.md
# PHY Management Register Init Sequencer

This block drives a fixed configuration program into a PHY's management register space once the PHY has left reset. It is the bus-side requester of a management-bus master: it presents one operation at a time (read or write, a 5-bit register address and 16-bit write data) and waits for that master to acknowledge the operation before it presents the next one. The serial management framing is handled by that separate master and is not part of this block.

The program is started by a one-cycle start pulse. It has four parts:

- An unlock pattern of three writes to register 0x14.
- A mode-enable write to register 0x17.
- A poll that reads register 0x14 until bit 14 of the returned word reads zero.
- A final write to register 0x14.

The poll is bounded by a limit value that the integration sets. If the limit runs out, the sequencer stops with an error flag and does not perform the final write. Busy, done and error outputs tell the surrounding logic where the sequence stands.

Top module: `phy_vcomp_seq`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) returns the block to idle. After that edge busy_o, done_o, err_o and mgmt_req_o are all low.
- R2: When the block is idle, start_i high at a clock edge starts the sequence. After that edge busy_o and mgmt_req_o are high, and the first operation is presented. A start_i pulse seen while busy_o is high has no effect on the operations issued.
- R3: The first three operations are writes (mgmt_we_o=1) to address 0x14, with data 0x0400, then 0x0000, then 0x0400.
- R4: The fourth operation is a write to address 0x17 with data 0x85E8.
- R5: Next the block issues reads (mgmt_we_o=0) of address 0x14. It issues another read for as long as bit 14 of the acknowledged mgmt_rdata_i is 1. All other read-data bits are ignored.
- R6: The first poll read that returns bit 14 = 0 is followed by exactly one more operation: a write of 0x4416 to address 0x14. When that write is acknowledged, done_o goes high and busy_o goes low.
- R7: mgmt_req_o stays high, with address, direction and write data unchanged, until a clock edge at which mgmt_ack_i is high. In the cycle after that edge mgmt_req_o is low.
- R8: Let M equal poll_limit_i as sampled at start, or 1 if that value is 0. If M poll reads in a row return bit 14 = 1, the block sets err_o and clears busy_o. It issues no further operation, so the final write does not happen.
- R9: busy_o stays high from the start until done or error. done_o and err_o are never both high, and neither is high while busy_o is high. A new start clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse |
| poll_limit_i | input | CNT_W | Maximum number of busy poll reads; 0 is treated as 1 |
| mgmt_req_o | output | 1 | Operation request to the management master |
| mgmt_we_o | output | 1 | 1 = write, 0 = read |
| mgmt_addr_o | output | 5 | Register address |
| mgmt_wdata_o | output | 16 | Write data |
| mgmt_rdata_i | input | 16 | Read data, valid with the acknowledge |
| mgmt_ack_i | input | 1 | Operation acknowledge |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence completed |
| err_o | output | 1 | Poll limit exhausted |

## Verification
The bench sweeps the poll limit (including the zero value) against the number of busy poll replies and the acknowledge latency. This covers the boundary where the busy count equals the limit. A design with an off-by-one in the limit would either perform the final write after an exhausted poll or report an error one read too early.

Busy replies set only bit 14, and clear replies set every other bit. A design that tested the wrong bit, or the whole word, would loop or stop at the wrong point.

A second start pulse is injected in the middle of a run, and a reset is applied in the middle of a run. A design that restarted on the second pulse would emit a duplicated unlock pattern. A design with a reset gap would leave busy or a request asserted.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    localparam int STEP_W     = 3;
    localparam int STEP_N     = 6;
    localparam int POLL_STEP  = 4;
    localparam int FINAL_STEP = 5;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int BUSY_BIT   = 14;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_GAP  = 2'd2
    } seq_st_e;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } mgmt_op_t;

endpackage

// File: rtl/seq_step_table.sv
module seq_step_table
    import phy_seq_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    output mgmt_op_t          op_o
);

    localparam logic [ADDR_W-1:0] CTRL_REG  = 5'h14;
    localparam logic [ADDR_W-1:0] MODE_REG  = 5'h17;
    localparam logic [DATA_W-1:0] KEY_ON    = 16'h0400;
    localparam logic [DATA_W-1:0] KEY_OFF   = 16'h0000;
    localparam logic [DATA_W-1:0] MODE_VAL  = 16'h85E8;
    localparam logic [DATA_W-1:0] FINAL_VAL = 16'h4416;

    always_comb begin
        op_o = '{we: 1'b1, addr: CTRL_REG, data: KEY_ON};
        case (step_i)
            3'd0: op_o = '{we: 1'b1, addr: CTRL_REG, data: KEY_ON};
            3'd1: op_o = '{we: 1'b1, addr: CTRL_REG, data: KEY_OFF};
            3'd2: op_o = '{we: 1'b1, addr: CTRL_REG, data: KEY_ON};
            3'd3: op_o = '{we: 1'b1, addr: MODE_REG, data: MODE_VAL};
            3'd4: op_o = '{we: 1'b0, addr: CTRL_REG, data: '0};
            3'd5: op_o = '{we: 1'b1, addr: CTRL_REG, data: FINAL_VAL};
            default: op_o = '{we: 1'b0, addr: CTRL_REG, data: '0};
        endcase
    end

endmodule

// File: rtl/seq_poll_guard.sv
module seq_poll_guard #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm_i,
    input  logic [CNT_W-1:0] limit_i,
    input  logic             busy_read_i,
    output logic             expire_o
);

    localparam int EXT_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] lim;
    } guard_t;

    guard_t g_d, g_q;
    logic [EXT_W-1:0] next_cnt;
    logic [EXT_W-1:0] lim_eff;

    always_comb begin
        g_d      = g_q;
        next_cnt = {1'b0, g_q.cnt} + EXT_W'(1);
        lim_eff  = (g_q.lim == '0) ? EXT_W'(1) : {1'b0, g_q.lim};
        expire_o = busy_read_i && (next_cnt >= lim_eff);
        if (arm_i) begin
            g_d.cnt = '0;
            g_d.lim = limit_i;
        end else if (busy_read_i && !expire_o) begin
            g_d.cnt = next_cnt[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) g_q <= '0;
        else     g_q <= g_d;
    end

    AST_POLL_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        (g_q.cnt == '0) || (g_q.cnt < g_q.lim)) else $error("poll count past limit"); // R8

endmodule

// File: rtl/phy_vcomp_seq.sv
module phy_vcomp_seq
    import phy_seq_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic [CNT_W-1:0] poll_limit_i,
    output logic             mgmt_req_o,
    output logic             mgmt_we_o,
    output logic [4:0]       mgmt_addr_o,
    output logic [15:0]      mgmt_wdata_o,
    input  logic [15:0]      mgmt_rdata_i,
    input  logic             mgmt_ack_i,
    output logic             busy_o,
    output logic             done_o,
    output logic             err_o
);

    typedef struct packed {
        seq_st_e           st;
        logic [STEP_W-1:0] step;
        logic              busy;
        logic              done;
        logic              err;
    } core_t;

    core_t    c_d, c_q;
    mgmt_op_t cur_op;
    logic     arm;
    logic     busy_read;
    logic     expire;
    logic     handshake;

    seq_step_table u_table (
        .step_i (c_q.step),
        .op_o   (cur_op)
    );

    seq_poll_guard #(.CNT_W(CNT_W)) u_guard (
        .clk         (clk),
        .rst         (rst),
        .arm_i       (arm),
        .limit_i     (poll_limit_i),
        .busy_read_i (busy_read),
        .expire_o    (expire)
    );

    always_comb begin
        c_d       = c_q;
        handshake = (c_q.st == ST_REQ) && mgmt_ack_i;
        arm       = (c_q.st == ST_IDLE) && start_i;
        busy_read = handshake && (c_q.step == STEP_W'(POLL_STEP)) && mgmt_rdata_i[BUSY_BIT];
        case (c_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    c_d.st   = ST_REQ;
                    c_d.step = '0;
                    c_d.busy = 1'b1;
                    c_d.done = 1'b0;
                    c_d.err  = 1'b0;
                end
            end
            ST_REQ: begin
                if (handshake) begin
                    if (c_q.step == STEP_W'(POLL_STEP)) begin
                        if (busy_read) begin
                            if (expire) begin
                                c_d.st   = ST_IDLE;
                                c_d.busy = 1'b0;
                                c_d.err  = 1'b1;
                            end else begin
                                c_d.st = ST_GAP;
                            end
                        end else begin
                            c_d.step = STEP_W'(FINAL_STEP);
                            c_d.st   = ST_GAP;
                        end
                    end else if (c_q.step == STEP_W'(FINAL_STEP)) begin
                        c_d.st   = ST_IDLE;
                        c_d.busy = 1'b0;
                        c_d.done = 1'b1;
                    end else begin
                        c_d.step = c_q.step + STEP_W'(1);
                        c_d.st   = ST_GAP;
                    end
                end
            end
            ST_GAP:  c_d.st = ST_REQ;
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q.st   <= ST_IDLE;
            c_q.step <= '0;
            c_q.busy <= 1'b0;
            c_q.done <= 1'b0;
            c_q.err  <= 1'b0;
        end else begin
            c_q <= c_d;
        end
    end

    assign mgmt_req_o   = (c_q.st == ST_REQ);
    assign mgmt_we_o    = cur_op.we;
    assign mgmt_addr_o  = cur_op.addr;
    assign mgmt_wdata_o = cur_op.data;
    assign busy_o       = c_q.busy;
    assign done_o       = c_q.done;
    assign err_o        = c_q.err;

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && !err_o && !mgmt_req_o)) else $error("reset"); // R1
    AST_START_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
        (start_i && !busy_o) |=> (busy_o && mgmt_req_o)) else $error("start"); // R2
    AST_POLL_IS_CTRL_READ: assert property (@(posedge clk) disable iff (rst)
        (mgmt_req_o && !mgmt_we_o) |-> (mgmt_addr_o == 5'h14)) else $error("poll addr"); // R5
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
        (mgmt_req_o && !mgmt_ack_i) |=> (mgmt_req_o && $stable(mgmt_addr_o)
            && $stable(mgmt_we_o) && $stable(mgmt_wdata_o))) else $error("req hold"); // R7
    AST_GAP_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
        (mgmt_req_o && mgmt_ack_i) |=> !mgmt_req_o) else $error("gap"); // R7
    AST_NO_REQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> !mgmt_req_o) else $error("idle req"); // R9
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(done_o && err_o)) else $error("flags"); // R9
    AST_FLAGS_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        (done_o || err_o) |-> !busy_o) else $error("flag busy"); // R9

endmodule

// File: tb/phy_vcomp_seq_tb_top.sv
module phy_vcomp_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  lim = 8'd0;
    logic        req, we, busy, done, err;
    logic [4:0]  addr;
    logic [15:0] wdata;
    logic [15:0] rdata = 16'h0;
    logic        ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int dly_cfg = 0;
    int busy_reads = 0;
    int rd_seen = 0;
    int wcnt = 0;
    int n_ops = 0;
    logic [4:0]  op_a [0:31];
    logic        op_w [0:31];
    logic [15:0] op_d [0:31];

    always #10 clk = ~clk;

    phy_vcomp_seq #(.CNT_W(8)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .start_i      (start),
        .poll_limit_i (lim),
        .mgmt_req_o   (req),
        .mgmt_we_o    (we),
        .mgmt_addr_o  (addr),
        .mgmt_wdata_o (wdata),
        .mgmt_rdata_i (rdata),
        .mgmt_ack_i   (ack),
        .busy_o       (busy),
        .done_o       (done),
        .err_o        (err)
    );

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    // bus responder: acknowledges after dly_cfg wait cycles, records operations
    always @(negedge clk) begin
        if (rst) begin
            ack = 1'b0;
            wcnt = 0;
        end else if (ack) begin
            ack = 1'b0;
            chk(req == 1'b0, "R7 gap after ack", {31'd0, req}, 32'd0);
        end else if (req) begin
            if (wcnt >= dly_cfg) begin
                ack = 1'b1;
                wcnt = 0;
                if (n_ops < 32) begin
                    op_a[n_ops] = addr;
                    op_w[n_ops] = we;
                    op_d[n_ops] = wdata;
                end
                if (!we) begin
                    rdata = (rd_seen < busy_reads) ? 16'h4000 : 16'hBFFF;
                    rd_seen++;
                end
                n_ops++;
            end else begin
                wcnt++;
            end
        end
    end

    task automatic run(input int lim_v, input int k, input int d, input bit restart);
        int eff;
        int reads;
        int total;
        bit ok_end;
        int t;
        n_ops = 0;
        rd_seen = 0;
        busy_reads = k;
        dly_cfg = d;
        lim = 8'(lim_v);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        chk(busy == 1'b1, "R2 busy after start", {31'd0, busy}, 32'd1);
        chk(req == 1'b1 && addr == 5'h14, "R2 first request", {26'd0, req, addr}, {26'd0, 1'b1, 5'h14});
        chk(!done && !err, "R9 flags cleared by start", {30'd0, done, err}, 32'd0);
        if (restart) begin
            repeat (3) @(negedge clk);
            start = 1'b1;
            @(negedge clk) start = 1'b0;
        end
        t = 0;
        while (busy && t < 3000) begin
            @(negedge clk);
            t++;
        end
        repeat (3) @(negedge clk);
        eff = (lim_v == 0) ? 1 : lim_v;
        ok_end = (k < eff);
        reads = ok_end ? k + 1 : eff;
        total = 4 + reads + (ok_end ? 1 : 0);
        chk(n_ops == total, ok_end ? "R6 op count" : "R8 op count", 32'(n_ops), 32'(total));
        for (int i = 0; i < total && i < 32; i++) begin
            if (i < 3) begin
                chk(op_w[i] && op_a[i] == 5'h14 && op_d[i] == ((i == 1) ? 16'h0000 : 16'h0400),
                    "R3 unlock write", {op_w[i], op_a[i], op_d[i]}, {1'b1, 5'h14, (i == 1) ? 16'h0000 : 16'h0400});
            end else if (i == 3) begin
                chk(op_w[i] && op_a[i] == 5'h17 && op_d[i] == 16'h85E8,
                    "R4 mode write", {op_w[i], op_a[i], op_d[i]}, {1'b1, 5'h17, 16'h85E8});
            end else if (i < 4 + reads) begin
                chk(!op_w[i] && op_a[i] == 5'h14, "R5 poll read", {op_w[i], op_a[i]}, {1'b0, 5'h14});
            end else begin
                chk(op_w[i] && op_a[i] == 5'h14 && op_d[i] == 16'h4416,
                    "R6 final write", {op_w[i], op_a[i], op_d[i]}, {1'b1, 5'h14, 16'h4416});
            end
        end
        chk(done == ok_end, "R6 done flag", {31'd0, done}, {31'd0, ok_end});
        chk(err == !ok_end, "R8 error flag", {31'd0, err}, {31'd0, !ok_end});
        chk(busy == 1'b0, "R9 busy cleared at end", {31'd0, busy}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && !req, "R1 reset state", {28'd0, busy, done, err, req}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        for (int lv = 0; lv < 4; lv++) begin
            for (int k = 0; k < 5; k++) begin
                for (int d = 0; d < 3; d++) begin
                    run(lv, k, d, ((k + d) % 2) == 1);
                end
            end
        end
        // reset in the middle of a run
        lim = 8'd3;
        busy_reads = 2;
        dly_cfg = 1;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (5) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !err && !req, "R1 mid-run reset", {28'd0, busy, done, err, req}, 32'd0);
        rst = 1'b0;
        run(2, 0, 0, 1'b0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule